// File: doc/BRIEF.md
# Duty-Cycled Receiver Power Sequencer

This block steps a satellite receiver through four graded power states: full power, CPU-only, standby and hibernate. Each state has its own set of domain enables for the RF front end, the DSP, the baseband clock and the baseband supply. The block raises its measurement-complete path into CPU-only, where the front end and DSP are off but the baseband keeps computing. Once a fix is reported, it rests in standby or hibernate. It leaves the rest state after a programmable period, or at once when the host asks for a wake.

Time is measured in ticks of a slow timebase. The tick is derived from the core clock, and the number of clock cycles per tick is a parameter. In push-to-fix mode the receiver rests in hibernate and returns to full power once per period. In the continuous duty-cycled mode it rests in standby instead. A separate tracker counts ticks since the last valid fix and reports whether a hot start is still allowed.

Top module: `pwr_seq`

## Requirements
- R1: After synchronous active-low reset the block is in full power: all four enables are 1, `wakeup` is 1 and `hot_ok` is 0.
- R2: In full power, with `meas_acq` high, `fix_valid` low and no pending first fix, the next cycle enters CPU-only, which drives {rf_en,dsp_en,bb_clk_en,bb_pwr_en} = 4'b0011 and `wakeup` = 0.
- R3: In CPU-only, if `meas_acq` drops without a fix, the next cycle returns to full power.
- R4: A fix in full power or CPU-only with `ptf_en` = 0 enters standby on the next cycle: enables 4'b0001, `wakeup` = 0. The baseband clock is never enabled without baseband power.
- R5: A fix in full power or CPU-only with `ptf_en` = 1 enters hibernate on the next cycle: enables 4'b0000, `wakeup` = 0.
- R6: From a rest state, the block returns to full power exactly P×CLK_PER_TICK cycles after the edge of the previous wake, where P is the active period in ticks.
- R7: A period written below PERIOD_MIN is used as PERIOD_MIN, and one above PERIOD_MAX is used as PERIOD_MAX.
- R8: `period_in` is sampled only at a timed wake, so a change applies from the following period on.
- R9: A one-cycle `wake_req` forces full power on the next cycle from any state and restarts the cycle with PERIOD_DEF, whatever `period_in` holds.
- R10: A rising edge of `ptf_en` forces full power on the next cycle. The block then stays in full power, ignoring `meas_acq`, until a fix arrives.
- R11: One cycle after `fix_valid` is sampled high, `hot_ok` is 1. It stays 1 while fewer than HOT_WIN ticks have elapsed since that fix.
- R12: Once HOT_WIN ticks elapse without a new fix, `hot_ok` returns to 0.
- R13: `wakeup` is 1 exactly when the block is in full power, that is, when all four enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_req | input | 1 | One-cycle qualified host wake pulse |
| fix_valid | input | 1 | Reliable navigation fix reported |
| meas_acq | input | 1 | Satellite measurements acquired |
| ptf_en | input | 1 | 1 selects push-to-fix (hibernate rest), 0 selects standby rest |
| period_in | input | PERIOD_W | Requested wake period in ticks |
| rf_en | output | 1 | RF domain enable |
| dsp_en | output | 1 | DSP domain enable |
| bb_clk_en | output | 1 | Baseband clock enable |
| bb_pwr_en | output | 1 | Baseband supply enable |
| wakeup | output | 1 | High only in full power |
| hot_ok | output | 1 | Hot start still allowed |

## Verification
The bench sweeps `period_in` from zero to beyond the upper limit and measures every wake-to-wake interval in cycles. This catches three kinds of error: a clamp that lets out-of-range values through, a period that is applied one cycle too early, and an off-by-one in the tick count that would stretch or shrink each interval by a whole tick. A host wake issued with a non-default period pending would expose a design that reuses the stale period instead of the default. Holding `meas_acq` high across a push-to-fix enable would expose a design that slips into CPU-only before the first fix. The hot-start window is sampled one tick before and a few ticks after its limit, which exposes an age counter that wraps or never saturates.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power sequencer.
// Assumes: state encoding is internal; only the decoded enables leave the block.
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_FULL = 2'd0,
        PS_CPU  = 2'd1,
        PS_STBY = 2'd2,
        PS_HIB  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic rf;
        logic dsp;
        logic bb_clk;
        logic bb_pwr;
    } dom_en_t;

endpackage

// File: rtl/pwr_tick_gen.sv
// Slow timebase: one-cycle tick every CLK_PER_TICK clocks.
// Assumes: restart realigns the phase so the first tick follows it by exactly
// CLK_PER_TICK cycles.
module pwr_tick_gen #(
    parameter int CLK_PER_TICK = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count clocks within a tick; wrap on tick, realign on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_period_timer.sv
// Wake period keeper: holds the active period, counts ticks since the last
// wake and flags a timed wake while the sequencer rests.
// Assumes: the requested period is sampled (after clamping) only at a timed
// wake; a host or mode wake loads the default period.
module pwr_period_timer #(
    parameter int PERIOD_W   = 13,
    parameter int PERIOD_MIN = 10,
    parameter int PERIOD_MAX = 7200,
    parameter int PERIOD_DEF = 1800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                restart_dflt,
    input  logic                resting,
    input  logic [PERIOD_W-1:0] period_in,
    output logic                timed_wake
);
    localparam logic [PERIOD_W-1:0] P_MIN = PERIOD_W'(PERIOD_MIN);
    localparam logic [PERIOD_W-1:0] P_MAX = PERIOD_W'(PERIOD_MAX);
    localparam logic [PERIOD_W-1:0] P_DEF = PERIOD_W'(PERIOD_DEF);

    logic [PERIOD_W-1:0] active_per;
    logic [PERIOD_W-1:0] elapsed;
    logic [PERIOD_W-1:0] clamped;
    logic [PERIOD_W:0]   elapsed_next;

    // Limit the requested period to the legal range.
    always_comb begin
        if (period_in < P_MIN) begin
            clamped = P_MIN;
        end else if (period_in > P_MAX) begin
            clamped = P_MAX;
        end else begin
            clamped = period_in;
        end
    end

    assign elapsed_next = {1'b0, elapsed} + 1'b1;
    assign timed_wake   = resting && tick && (elapsed_next >= {1'b0, active_per});

    // Track the active period and the ticks elapsed since the last wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_per <= P_DEF;
            elapsed    <= '0;
        end else if (restart_dflt) begin
            active_per <= P_DEF;
            elapsed    <= '0;
        end else if (timed_wake) begin
            active_per <= clamped;
            elapsed    <= '0;
        end else if (tick && (elapsed != '1)) begin
            elapsed    <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_hot_track.sv
// Hot-start tracker: ages the last valid fix in ticks and reports whether it
// is younger than HOT_WIN ticks.
// Assumes: the age saturates at HOT_WIN, so it never wraps back into the window.
module pwr_hot_track #(
    parameter int HOT_WIN = 7200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fix_valid,
    output logic hot_ok
);
    localparam int AW = $clog2(HOT_WIN + 1);
    localparam logic [AW-1:0] AGE_LIM = AW'(HOT_WIN);

    logic [AW-1:0] age;
    logic          have_fix;

    // Restart the age at each fix; otherwise age one step per tick up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age      <= '0;
            have_fix <= 1'b0;
        end else if (fix_valid) begin
            age      <= '0;
            have_fix <= 1'b1;
        end else if (tick && (age != AGE_LIM)) begin
            age      <= age + 1'b1;
        end
    end

    assign hot_ok = have_fix && (age < AGE_LIM);
endmodule

// File: rtl/pwr_state_fsm.sv
// Power state machine and domain decode.
// Assumes: wake_any already merges host, mode-enable and timed wakes;
// a push-to-fix enable edge blocks the CPU-only shortcut until the first fix.
module pwr_state_fsm
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wake_any,
    input  logic    fix_valid,
    input  logic    meas_acq,
    input  logic    ptf_en,
    output logic    ptf_rise,
    output logic    resting,
    output dom_en_t dom,
    output logic    wakeup
);
    pwr_state_e state, state_nx;
    pwr_state_e rest_sel;
    logic       ptf_prev;
    logic       first_pend;

    assign ptf_rise = ptf_en && !ptf_prev;
    assign rest_sel = ptf_en ? PS_HIB : PS_STBY;
    assign resting  = (state == PS_STBY) || (state == PS_HIB);

    // Choose the next power state; any wake has priority over the fix path.
    always_comb begin
        state_nx = state;
        if (wake_any) begin
            state_nx = PS_FULL;
        end else begin
            unique case (state)
                PS_FULL: begin
                    if (fix_valid) begin
                        state_nx = rest_sel;
                    end else if (meas_acq && !first_pend) begin
                        state_nx = PS_CPU;
                    end
                end
                PS_CPU: begin
                    if (fix_valid) begin
                        state_nx = rest_sel;
                    end else if (!meas_acq) begin
                        state_nx = PS_FULL;
                    end
                end
                default: state_nx = state;
            endcase
        end
    end

    // Register the state, the previous mode bit and the first-fix hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PS_FULL;
            ptf_prev   <= 1'b0;
            first_pend <= 1'b0;
        end else begin
            state    <= state_nx;
            ptf_prev <= ptf_en;
            if (ptf_rise) begin
                first_pend <= 1'b1;
            end else if (fix_valid || !ptf_en) begin
                first_pend <= 1'b0;
            end
        end
    end

    // Map the state onto the per-domain enables.
    always_comb begin
        unique case (state)
            PS_FULL: dom = '{rf: 1'b1, dsp: 1'b1, bb_clk: 1'b1, bb_pwr: 1'b1};
            PS_CPU:  dom = '{rf: 1'b0, dsp: 1'b0, bb_clk: 1'b1, bb_pwr: 1'b1};
            PS_STBY: dom = '{rf: 1'b0, dsp: 1'b0, bb_clk: 1'b0, bb_pwr: 1'b1};
            default: dom = '{rf: 1'b0, dsp: 1'b0, bb_clk: 1'b0, bb_pwr: 1'b0};
        endcase
    end

    assign wakeup = (state == PS_FULL);
endmodule

// File: rtl/pwr_seq.sv
// Top of the duty-cycled receiver power sequencer: timebase, wake period
// keeper, state machine and hot-start tracker.
// Assumes: wake_req is already debounced to a single-cycle pulse; period_in
// is in ticks of the slow timebase.
module pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int CLK_PER_TICK = 32768,
    parameter int PERIOD_W     = 13,
    parameter int PERIOD_MIN   = 10,
    parameter int PERIOD_MAX   = 7200,
    parameter int PERIOD_DEF   = 1800,
    parameter int HOT_WIN      = 7200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wake_req,
    input  logic                fix_valid,
    input  logic                meas_acq,
    input  logic                ptf_en,
    input  logic [PERIOD_W-1:0] period_in,
    output logic                rf_en,
    output logic                dsp_en,
    output logic                bb_clk_en,
    output logic                bb_pwr_en,
    output logic                wakeup,
    output logic                hot_ok
);
    logic    tick;
    logic    timed_wake;
    logic    ptf_rise;
    logic    resting;
    logic    restart_dflt;
    logic    wake_any;
    dom_en_t dom;

    assign restart_dflt = wake_req || ptf_rise;
    assign wake_any     = restart_dflt || timed_wake;

    pwr_tick_gen #(
        .CLK_PER_TICK (CLK_PER_TICK)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wake_any),
        .tick    (tick)
    );

    pwr_period_timer #(
        .PERIOD_W   (PERIOD_W),
        .PERIOD_MIN (PERIOD_MIN),
        .PERIOD_MAX (PERIOD_MAX),
        .PERIOD_DEF (PERIOD_DEF)
    ) u_period (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .restart_dflt (restart_dflt),
        .resting      (resting),
        .period_in    (period_in),
        .timed_wake   (timed_wake)
    );

    pwr_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_any  (wake_any),
        .fix_valid (fix_valid),
        .meas_acq  (meas_acq),
        .ptf_en    (ptf_en),
        .ptf_rise  (ptf_rise),
        .resting   (resting),
        .dom       (dom),
        .wakeup    (wakeup)
    );

    pwr_hot_track #(
        .HOT_WIN (HOT_WIN)
    ) u_hot (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fix_valid (fix_valid),
        .hot_ok    (hot_ok)
    );

    assign rf_en     = dom.rf;
    assign dsp_en    = dom.dsp;
    assign bb_clk_en = dom.bb_clk;
    assign bb_pwr_en = dom.bb_pwr;
endmodule

// File: rtl/pwr_seq_chk.sv
// Port-level protocol checks for the power sequencer, attached by bind.
// Assumes: all properties are disabled while reset is low.
module pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wake_req,
    input logic fix_valid,
    input logic ptf_en,
    input logic rf_en,
    input logic dsp_en,
    input logic bb_clk_en,
    input logic bb_pwr_en,
    input logic wakeup,
    input logic hot_ok
);
    // R13
    full_only_wakeup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |-> (rf_en && dsp_en && bb_clk_en && bb_pwr_en));

    // R13
    rf_implies_wakeup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |-> wakeup);

    // R4
    clk_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bb_clk_en |-> bb_pwr_en);

    // R9
    wake_req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> wakeup);

    // R10
    ptf_rise_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ptf_en) |=> wakeup);

    // R5
    fix_rests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_valid && !wake_req && !$rose(ptf_en)) |=> !wakeup);

    // R11
    fix_sets_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |=> hot_ok);
endmodule

bind pwr_seq pwr_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_req  (wake_req),
    .fix_valid (fix_valid),
    .ptf_en    (ptf_en),
    .rf_en     (rf_en),
    .dsp_en    (dsp_en),
    .bb_clk_en (bb_clk_en),
    .bb_pwr_en (bb_pwr_en),
    .wakeup    (wakeup),
    .hot_ok    (hot_ok)
);

// File: tb/pwr_seq_test.sv
// Self-checking bench for pwr_seq on a small configuration.
module pwr_seq_test;
    localparam int DIV  = 2;
    localparam int PW   = 13;
    localparam int PMIN = 3;
    localparam int PMAX = 12;
    localparam int PDEF = 5;
    localparam int HOT  = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wake_req = 1'b0;
    logic          fix_valid = 1'b0;
    logic          meas_acq = 1'b0;
    logic          ptf_en = 1'b0;
    logic [PW-1:0] period_in = '0;
    logic          rf_en, dsp_en, bb_clk_en, bb_pwr_en, wakeup, hot_ok;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pwr_seq #(
        .CLK_PER_TICK (DIV),
        .PERIOD_W     (PW),
        .PERIOD_MIN   (PMIN),
        .PERIOD_MAX   (PMAX),
        .PERIOD_DEF   (PDEF),
        .HOT_WIN      (HOT)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_req  (wake_req),
        .fix_valid (fix_valid),
        .meas_acq  (meas_acq),
        .ptf_en    (ptf_en),
        .period_in (period_in),
        .rf_en     (rf_en),
        .dsp_en    (dsp_en),
        .bb_clk_en (bb_clk_en),
        .bb_pwr_en (bb_pwr_en),
        .wakeup    (wakeup),
        .hot_ok    (hot_ok)
    );

    function automatic int clampp(int p);
        if (p < PMIN) return PMIN;
        if (p > PMAX) return PMAX;
        return p;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int en4();
        return {28'd0, rf_en, dsp_en, bb_clk_en, bb_pwr_en};
    endfunction

    // Pulse a fix right after a wake and count cycles to the next wake.
    task automatic measure(output int n, output int rest_en);
        fix_valid = 1'b1;
        n = 0;
        rest_en = -1;
        do begin
            @(negedge clk);
            n++;
            fix_valid = 1'b0;
            if (n == 1) rest_en = en4();
        end while (!wakeup && n < 200);
    endtask

    task automatic host_wake(string tag);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        check(tag, wakeup, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, re, prev;
        repeat (2) @(negedge clk);
        check("R1 enables", en4(), 15);
        check("R1 wakeup", wakeup, 1);
        check("R1 hot_ok", hot_ok, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // CPU-only entry and exit
        meas_acq = 1'b1;
        @(negedge clk);
        check("R2 cpu enables", en4(), 3);
        check("R2 cpu wakeup", wakeup, 0);
        meas_acq = 1'b0;
        @(negedge clk);
        check("R3 back to full", en4(), 15);
        meas_acq = 1'b1;
        @(negedge clk);
        check("R2 cpu again", en4(), 3);
        fix_valid = 1'b1;
        @(negedge clk);
        fix_valid = 1'b0;
        meas_acq = 1'b0;
        check("R4 standby enables", en4(), 1);
        check("R4 standby wakeup", wakeup, 0);
        check("R11 hot after fix", hot_ok, 1);

        // Host wake loads the default period whatever period_in holds
        period_in = PW'(0);
        host_wake("R9 wake from standby");
        measure(n, re);
        check("R4 rest is standby", re, 1);
        check("R9 default interval", n, PDEF * DIV);
        prev = clampp(0);

        // Period sweep: each write shows up one period late, clamped
        for (int p = 0; p <= PMAX + 3; p++) begin
            period_in = PW'(p);
            measure(n, re);
            check("R8 old period kept", n, prev * DIV);
            measure(n, re);
            check("R7 R6 clamped interval", n, clampp(p) * DIV);
            prev = clampp(p);
        end

        // Push-to-fix enable holds full power despite measurements
        meas_acq = 1'b1;
        ptf_en = 1'b1;
        @(negedge clk);
        check("R10 full on enable", wakeup, 1);
        repeat (3) @(negedge clk);
        check("R10 held until fix", en4(), 15);
        fix_valid = 1'b1;
        @(negedge clk);
        fix_valid = 1'b0;
        meas_acq = 1'b0;
        check("R5 hibernate enables", en4(), 0);
        check("R5 hibernate wakeup", wakeup, 0);

        // Push-to-fix periodic wake from hibernate
        period_in = PW'(7);
        host_wake("R9 wake from hibernate");
        measure(n, re);
        check("R5 rest is hibernate", re, 0);
        check("R9 ptf default interval", n, PDEF * DIV);
        measure(n, re);
        check("R6 ptf interval", n, 7 * DIV);

        // Hot-start window: fix, then no more fixes
        period_in = PW'(PMAX);
        fix_valid = 1'b1;
        @(negedge clk);
        fix_valid = 1'b0;
        check("R11 hot set", hot_ok, 1);
        repeat ((HOT - 1) * DIV - 1) @(negedge clk);
        check("R11 hot inside window", hot_ok, 1);
        repeat (4 * DIV) @(negedge clk);
        check("R12 hot expired", hot_ok, 0);

        // Reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset enables", en4(), 15);
        check("R1 reset hot_ok", hot_ok, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule